// File: doc/BRIEF.md
# Status Register and Block Write Protection Unit

This unit sits beside the command decoder and the self-timed programming engine of a serial nonvolatile memory. It keeps the write enable latch and three persistent control bits: a two-bit protection level and a hardware-lock enable. From these it assembles the byte returned by a status read. It also answers two questions at all times: may the array byte at the address under test be written, and may the status register itself be written.

Protection has two layers. The protection level fences off the top quarter, the top half or the whole array. A write-protect pin, which acts only while the lock-enable bit is set, freezes the status register, including the lock-enable bit itself. A status update is captured while chip select is low and launched when chip select rises. It then occupies the same timed busy cycle as an array write. If the write-protect pin falls before the launch, the captured update is dropped. Once the launch has happened, the pin no longer affects it. The write-protect pin passes through a parameterised synchroniser before use. Reset models a blank device: every bit is zero.

Top module: `srp_status_protect`

## Requirements
- R1: After reset the status byte is 0x00, and both array and status write permissions are low.
- R2: A set-enable strobe makes status bit 1 read 1. A clear-enable strobe makes it read 0. When both strobes arrive in the same cycle, the clear wins.
- R3: While busy is high the status byte reads 0xFF.
- R4: The protection level sits in status bits 3:2. For a 10-bit address, level 0 protects nothing, level 1 protects 0x300..0x3FF, level 2 protects 0x200..0x3FF and level 3 protects every address. A protected address is never writable.
- R5: With the enable latch at 0, the array write permission is low for every address.
- R6: With lock-enable (status bit 7) at 1 and the write-protect pin low, status write permission is low. A status write attempt is then ignored: it gives no launch pulse and leaves bits 7 and 3:2 unchanged. Unprotected array addresses stay writable.
- R7: With lock-enable at 0, a low write-protect pin has no effect, and status writes launch and take effect.
- R8: A captured status write is cancelled when the hardware lock becomes active before chip select rises. No launch pulse follows, and the stored bits are unchanged.
- R9: A status write that has already launched is applied at the end of its cycle, even if the write-protect pin falls during the busy period.
- R10: A launched status write takes effect at the cycle-done strobe. Every cycle-done strobe also clears the enable latch.
- R11: While busy is high, set-enable, clear-enable and status-write strobes are ignored, and both write permissions are low.
- R12: Status bits 6:4 and bit 0 read 0 when idle, whatever value was written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_wen_i | input | 1 | Set-enable command strobe |
| clr_wen_i | input | 1 | Clear-enable command strobe |
| stat_wr_i | input | 1 | Status-write data byte received (chip select still low) |
| stat_data_i | input | 8 | Data byte of the status-write command |
| sel_n_i | input | 1 | Chip select, active low |
| wp_n_i | input | 1 | Write-protect pin, active low, asynchronous |
| busy_i | input | 1 | Internal programming cycle running |
| cycle_done_i | input | 1 | Last cycle of the programming cycle |
| chk_addr_i | input | ADDR_W | Array address whose writability is reported |
| status_o | output | 8 | Status byte |
| arr_wr_ok_o | output | 1 | Array byte at chk_addr_i may be written |
| stat_wr_ok_o | output | 1 | Status register may be written |
| stat_start_o | output | 1 | One-cycle pulse launching a status programming cycle |

## Verification
The key interaction is a captured status write meeting a falling write-protect pin. Two outcomes must be separated. A pin fall that reaches the lock before chip select rises cancels the write. A fall that arrives during the busy period after the launch has no effect. The bench provokes both orders with the same data byte. It judges each one by the presence of the launch pulse and by the status byte read back once the cycle-done strobe has passed. A second collision, set-enable and clear-enable in one cycle, is driven directly and must leave the latch cleared.

// File: rtl/srp_pkg.sv
package srp_pkg;
   localparam int STAT_W   = 8;
   localparam int POS_LOCK = 7;
   localparam int POS_LVLH = 3;
   localparam int POS_LVLL = 2;
   localparam int POS_WEN  = 1;
   localparam int POS_BUSY = 0;

   typedef enum logic [1:0] {
      PL_NONE    = 2'b00,
      PL_QUARTER = 2'b01,
      PL_HALF    = 2'b10,
      PL_ALL     = 2'b11
   } prot_lvl_t;

   typedef enum logic [1:0] {
      SW_IDLE   = 2'b00,
      SW_ARMED  = 2'b01,
      SW_STAGED = 2'b10
   } sw_state_t;

   typedef struct packed {
      logic       lock_en;
      logic [1:0] level;
   } nv_bits_t;
endpackage

// File: rtl/srp_wp_sync.sv
module srp_wp_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wp_n_i,
   output logic wp_n_o
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign wp_n_o = wp_n_i;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2:0], wp_n_i};
         end
         assign wp_n_o = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/srp_block_decode.sv
module srp_block_decode
   import srp_pkg::*;
#(
   parameter int ADDR_W = 10
) (
   input  prot_lvl_t          level_i,
   input  logic [ADDR_W-1:0]  addr_i,
   output logic               in_prot_o
);
   localparam int TOP = ADDR_W - 1;

   always_comb begin
      unique case (level_i)
         PL_NONE:    in_prot_o = 1'b0;
         PL_QUARTER: in_prot_o = &addr_i[TOP -: 2];
         PL_HALF:    in_prot_o = addr_i[TOP];
         default:    in_prot_o = 1'b1;
      endcase
   end
endmodule

// File: rtl/srp_status_core.sv
module srp_status_core
   import srp_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     set_wen_i,
   input  logic     clr_wen_i,
   input  logic     stat_wr_i,
   input  nv_bits_t wr_bits_i,
   input  logic     sel_n_i,
   input  logic     hw_lock_i,
   input  logic     busy_i,
   input  logic     cycle_done_i,
   output logic     wen_o,
   output nv_bits_t bits_o,
   output logic     start_o
);
   sw_state_t state_q;
   nv_bits_t  stage_q;
   nv_bits_t  bits_q;
   logic      wen_q;
   logic      start_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SW_IDLE;
         stage_q <= '0;
         bits_q  <= '0;
         wen_q   <= 1'b0;
         start_q <= 1'b0;
      end else begin
         start_q <= 1'b0;
         if (cycle_done_i) begin
            wen_q <= 1'b0;
            if (state_q == SW_STAGED) begin
               bits_q  <= stage_q;
               state_q <= SW_IDLE;
            end
         end else if (!busy_i) begin
            if (clr_wen_i)      wen_q <= 1'b0;
            else if (set_wen_i) wen_q <= 1'b1;
            unique case (state_q)
               SW_IDLE: begin
                  if (stat_wr_i && !sel_n_i && wen_q && !hw_lock_i) begin
                     stage_q <= wr_bits_i;
                     state_q <= SW_ARMED;
                  end
               end
               SW_ARMED: begin
                  if (hw_lock_i) begin
                     state_q <= SW_IDLE;
                  end else if (sel_n_i) begin
                     state_q <= SW_STAGED;
                     start_q <= 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign wen_o   = wen_q;
   assign bits_o  = bits_q;
   assign start_o = start_q;
endmodule

// File: rtl/srp_status_protect.sv
module srp_status_protect
   import srp_pkg::*;
#(
   parameter int ADDR_W      = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_wen_i,
   input  logic              clr_wen_i,
   input  logic              stat_wr_i,
   input  logic [7:0]        stat_data_i,
   input  logic              sel_n_i,
   input  logic              wp_n_i,
   input  logic              busy_i,
   input  logic              cycle_done_i,
   input  logic [ADDR_W-1:0] chk_addr_i,
   output logic [7:0]        status_o,
   output logic              arr_wr_ok_o,
   output logic              stat_wr_ok_o,
   output logic              stat_start_o
);
   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("srp_status_protect: ADDR_W must be at least 2");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
         $error("srp_status_protect: SYNC_STAGES must lie in 0..3");
      end
   endgenerate

   logic     wp_n_s;
   logic     hw_lock;
   logic     wen;
   logic     in_prot;
   nv_bits_t bits;
   nv_bits_t wr_bits;
   logic     unused_data;

   assign wr_bits     = '{lock_en: stat_data_i[POS_LOCK],
                          level:   stat_data_i[POS_LVLH:POS_LVLL]};
   assign unused_data = ^{stat_data_i[6:4], stat_data_i[POS_WEN], stat_data_i[POS_BUSY]};

   srp_wp_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .wp_n_i (wp_n_i),
      .wp_n_o (wp_n_s)
   );

   assign hw_lock = bits.lock_en & ~wp_n_s;

   srp_status_core i_core (
      .clk          (clk),
      .rst_n        (rst_n),
      .set_wen_i    (set_wen_i),
      .clr_wen_i    (clr_wen_i),
      .stat_wr_i    (stat_wr_i),
      .wr_bits_i    (wr_bits),
      .sel_n_i      (sel_n_i),
      .hw_lock_i    (hw_lock),
      .busy_i       (busy_i),
      .cycle_done_i (cycle_done_i),
      .wen_o        (wen),
      .bits_o       (bits),
      .start_o      (stat_start_o)
   );

   srp_block_decode #(.ADDR_W(ADDR_W)) i_decode (
      .level_i   (prot_lvl_t'(bits.level)),
      .addr_i    (chk_addr_i),
      .in_prot_o (in_prot)
   );

   always_comb begin
      if (busy_i) begin
         status_o = '1;
      end else begin
         status_o           = '0;
         status_o[POS_LOCK] = bits.lock_en;
         status_o[POS_LVLH:POS_LVLL] = bits.level;
         status_o[POS_WEN]  = wen;
      end
   end

   assign arr_wr_ok_o  = wen & ~in_prot & ~busy_i;
   assign stat_wr_ok_o = wen & ~hw_lock & ~busy_i;
endmodule

// File: rtl/srp_status_protect_chk.sv
module srp_status_protect_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       set_wen_i,
   input logic       clr_wen_i,
   input logic       busy_i,
   input logic       cycle_done_i,
   input logic [7:0] status_o,
   input logic       arr_wr_ok_o,
   input logic       stat_wr_ok_o,
   input logic       stat_start_o
);
   assert_busy_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |-> (!arr_wr_ok_o && !stat_wr_ok_o));

   assert_clear_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wen_i && !busy_i && !cycle_done_i) |=> (busy_i || !status_o[1]));

   assert_all_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_i && status_o[3:2] == 2'b11) |-> !arr_wr_ok_o);

   assert_done_clears_wen_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_done_i |=> (busy_i || !status_o[1]));

   assert_start_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      stat_start_o |=> !stat_start_o);

   assert_no_enable_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_i && !status_o[1]) |-> (!arr_wr_ok_o && !stat_wr_ok_o));

   assert_unused_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_i && !$past(busy_i) && !set_wen_i) |-> (status_o[6:4] == 3'b000));
endmodule

bind srp_status_protect srp_status_protect_chk i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .set_wen_i    (set_wen_i),
   .clr_wen_i    (clr_wen_i),
   .busy_i       (busy_i),
   .cycle_done_i (cycle_done_i),
   .status_o     (status_o),
   .arr_wr_ok_o  (arr_wr_ok_o),
   .stat_wr_ok_o (stat_wr_ok_o),
   .stat_start_o (stat_start_o)
);

// File: tb/test_srp_status_protect.sv
`timescale 1ns/100ps
module test_srp_status_protect;
   localparam int AW = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          set_wen = 1'b0, clr_wen = 1'b0, stat_wr = 1'b0;
   logic [7:0]    stat_data = '0;
   logic          sel_n = 1'b1, wp_n = 1'b1, busy = 1'b0, done = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [7:0]    status;
   logic          arr_ok, stat_ok, start;
   int            n_run = 0, n_fail = 0;
   logic          finished = 1'b0;

   always #2.5 clk = ~clk;

   srp_status_protect #(.ADDR_W(AW), .SYNC_STAGES(2)) i_srp_status_protect (
      .clk(clk), .rst_n(rst_n), .set_wen_i(set_wen), .clr_wen_i(clr_wen),
      .stat_wr_i(stat_wr), .stat_data_i(stat_data), .sel_n_i(sel_n),
      .wp_n_i(wp_n), .busy_i(busy), .cycle_done_i(done), .chk_addr_i(addr),
      .status_o(status), .arr_wr_ok_o(arr_ok), .stat_wr_ok_o(stat_ok),
      .stat_start_o(start));

   // {level[1:0], addr[9:0], expected writable}
   localparam logic [12:0] VEC [8] = '{
      {2'b00, 10'h3FF, 1'b1}, {2'b01, 10'h2FF, 1'b1},
      {2'b01, 10'h300, 1'b0}, {2'b10, 10'h1FF, 1'b1},
      {2'b10, 10'h200, 1'b0}, {2'b11, 10'h000, 1'b0},
      {2'b00, 10'h000, 1'b1}, {2'b01, 10'h3FF, 1'b0}};

   task automatic tick(int n = 1);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic do_set();
      set_wen = 1'b1; tick(); set_wen = 1'b0;
   endtask

   task automatic finish_cycle();
      busy = 1'b1; tick(3);
      done = 1'b1; tick();
      done = 1'b0; busy = 1'b0; tick();
   endtask

   task automatic capture(input logic [7:0] d);
      do_set();
      sel_n = 1'b0; stat_wr = 1'b1; stat_data = d; tick();
      stat_wr = 1'b0; tick();
   endtask

   task automatic wr_status(input logic [7:0] d, output logic started);
      capture(d);
      sel_n = 1'b1; tick();
      started = start;
      finish_cycle();
   endtask

   initial begin
      #200000;
      if (!finished) begin
         n_fail++; n_run++;
         $display("FAIL watchdog: actual 0x00 expected 0x01");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic st;
      tick(2);
      // R1 reset state
      chk("R1 status", status, 8'h00);
      chk("R1 perms", {6'b0, arr_ok, stat_ok}, 8'h00);
      rst_n = 1'b1; tick();

      // R5 no enable, nothing writable
      chk("R5 arr refused", {7'b0, arr_ok}, 8'h00);

      // R2 enable latch, clear wins on collision
      do_set();
      chk("R2 set", status, 8'h02);
      set_wen = 1'b1; clr_wen = 1'b1; tick(); set_wen = 1'b0; clr_wen = 1'b0;
      chk("R2 clear wins", status, 8'h00);
      do_set(); clr_wen = 1'b1; tick(); clr_wen = 1'b0;
      chk("R2 clear", status, 8'h00);

      // R4 table of protection levels
      for (int k = 0; k < 8; k++) begin
         wr_status({4'b0, VEC[k][12:11], 2'b00}, st);
         do_set();
         addr = VEC[k][10:1]; tick();
         chk($sformatf("R4 vec%0d", k), {7'b0, arr_ok}, {7'b0, VEC[k][0]});
      end

      // R12 and R10: unused bits dropped, enable cleared at done
      wr_status(8'h7F, st);
      chk("R12 unused zero", status, 8'h0C);
      chk("R10 wen cleared", {7'b0, status[1]}, 8'h00);

      // R3 and R11: busy behaviour
      busy = 1'b1; tick();
      chk("R3 busy byte", status, 8'hFF);
      set_wen = 1'b1; tick(); set_wen = 1'b0;
      chk("R11 perms low", {6'b0, arr_ok, stat_ok}, 8'h00);
      busy = 1'b0; tick();
      chk("R11 set ignored", status, 8'h0C);

      // R7 lock disabled: WP low has no effect
      wp_n = 1'b0; tick(3);
      wr_status(8'h80, st);
      chk("R7 launched", {7'b0, st}, 8'h01);
      chk("R7 applied", status, 8'h80);

      // R6 hardware lock active
      do_set();
      chk("R6 stat perm", {7'b0, stat_ok}, 8'h00);
      addr = 10'h000; tick();
      chk("R6 array ok", {7'b0, arr_ok}, 8'h01);
      wr_status(8'h00, st);
      chk("R6 no launch", {7'b0, st}, 8'h00);
      chk("R6 bits kept", status, 8'h80);

      // release pin, program a known level
      wp_n = 1'b1; tick(3);
      wr_status(8'h88, st);
      chk("R10 applied", status, 8'h88);

      // R8 pin falls before launch: cancelled
      capture(8'h84);
      wp_n = 1'b0; tick(3);
      sel_n = 1'b1; tick();
      chk("R8 no launch", {7'b0, start}, 8'h00);
      finish_cycle();
      chk("R8 bits kept", status, 8'h88);
      wp_n = 1'b1; tick(3);

      // R9 pin falls after launch: applied
      capture(8'h84);
      sel_n = 1'b1; tick();
      chk("R9 launched", {7'b0, start}, 8'h01);
      wp_n = 1'b0;
      finish_cycle();
      chk("R9 applied", status, 8'h84);
      wp_n = 1'b1; tick(3);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule